// File: doc/BRIEF.md
# Multi-Channel Timer Bank with Watchdog Reset

A bank of identical 16-bit count-up timers behind a plain 16-bit register port. Each channel has a setup word, a counter and two compare values. It counts pulses from a slow reference (a single-cycle `tick_i` strobe stands for each edge of the 32 kHz source) or from the system clock. Those pulses pass through a power-of-two prescaler chosen in the setup word. With an exponent of 13 and the tick source, the counter steps at 4 Hz.

The setup word can be written only once after reset. That first write fixes the prescaler, the source select and both compare enables, and sets a lock bit. Later writes may change only the run bit, and may clear the two event flags by writing 1 to them. A channel that was never configured reads back zero from its setup word, so software can scan for a free channel.

A separate interrupt-configuration word holds one NMI-enable bit and one reset-enable bit per channel. A channel whose compare-2 event flag is set drives the reset request when its reset-enable bit is set, and the NMI request when its NMI-enable bit is set. A request stays asserted until the flag is cleared or the enable bit is dropped. This makes the bank usable as a watchdog. Software loads the counter, sets a compare-2 limit and enables the reset. It then keeps rewriting the counter before the limit is reached.

Top module: `mft_bank`

## Requirements
- R1: After reset every readable register is 0, and `rst_req_o` and `nmi_req_o` are low. An unused channel's setup word reads 0.
- R2: The first write to a channel's setup word (address select 3) stores these fields: run at bit 15, compare-2 enable at bit 9, compare-1 enable at bit 8, clock-fast at bit 4 and prescale exponent at bits 3:0. It also sets the lock bit at bit 12.
- R3: Once the lock bit is set, a setup write changes only bit 15. Writing 1 to bit 14 clears the compare-2 flag and writing 1 to bit 13 clears the compare-1 flag. Every other field stays unchanged.
- R4: A write to address select 2 loads the counter directly with the written value.
- R5: The counter and its prescaler advance only while the run bit is 1. Clearing the run bit holds both the count and the prescaler phase.
- R6: With exponent e, the counter advances once every 2^e source pulses. The source is `tick_i` when bit 4 is 0, and every clock cycle when bit 4 is 1.
- R7: The counter stops at its maximum value (0xFFFF) and does not wrap.
- R8: While the channel runs, the compare-n flag is set on the next edge when three things hold: the counter equals compare-n (select 0 for compare 1, select 1 for compare 2), and the compare-n enable bit is set. The flag stays set until it is cleared by a write of 1. A clear takes priority over a set in the same cycle.
- R9: `rst_req_o` is high while any channel c has its compare-2 flag set and configuration bit NUM_CH+c set. `nmi_req_o` is high under the same condition using bit c.
- R10: The register address is {channel, select}. An address with a channel index at or above NUM_CH reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe per edge of the slow reference |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | CH_W+2 | Register address {channel, select} |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_cfg_wr | input | 1 | Write strobe for the interrupt-configuration word |
| irq_cfg_wdata | input | 2*NUM_CH | NMI enables in the low half, reset enables in the high half |
| rst_req_o | output | 1 | System reset request |
| nmi_req_o | output | 1 | Non-maskable interrupt request |

## Verification
The bench builds the bank with its defaults: six channels and a 16-bit counter. That makes the three-bit channel field reach unused channel indices 6 and 7. Selecting the clock-fast source with exponent 0 brings compare matches and flag setting within a few tens of cycles. Saturation is reached by loading the counter just below 0xFFFF. A tick-driven channel with exponent 2 exposes the prescaler phase across a pause and resume of the run bit.

// File: rtl/mft_pkg.sv
package mft_pkg;
  localparam int REG_W     = 16;
  localparam int PRE_BITS  = 4;
  localparam int SET_RUN   = 15;
  localparam int SET_F2    = 14;
  localparam int SET_F1    = 13;
  localparam int SET_LOCK  = 12;
  localparam int SET_C2EN  = 9;
  localparam int SET_C1EN  = 8;
  localparam int SET_FAST  = 4;

  typedef enum logic [1:0] {
    SEL_CMP1  = 2'd0,
    SEL_CMP2  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_SETUP = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic                run;
    logic                f2;
    logic                f1;
    logic                lock;
    logic                c2en;
    logic                c1en;
    logic                fast;
    logic [PRE_BITS-1:0] pre;
  } setup_t;

  function automatic logic [REG_W-1:0] setup_word(setup_t s);
    logic [REG_W-1:0] w;
    w = '0;
    w[SET_RUN]  = s.run;
    w[SET_F2]   = s.f2;
    w[SET_F1]   = s.f1;
    w[SET_LOCK] = s.lock;
    w[SET_C2EN] = s.c2en;
    w[SET_C1EN] = s.c1en;
    w[SET_FAST] = s.fast;
    w[PRE_BITS-1:0] = s.pre;
    return w;
  endfunction
endpackage

// File: rtl/mft_prescaler.sv
module mft_prescaler #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src,
  input  logic [EXP_W-1:0] exp_i,
  output logic             step_o
);
  localparam int PRE_W = (2 ** EXP_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask   = ~({PRE_W{1'b1}} << exp_i);
  assign step_o = run && src && (pre_q == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (run && src) begin
      pre_q <= step_o ? '0 : pre_q + 1'b1;
    end
  end

  // R5
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pre_q));
endmodule

// File: rtl/mft_channel.sv
module mft_channel
  import mft_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  wr_en,
  input  reg_sel_e              wr_sel,
  input  logic [REG_W-1:0]      wr_data,
  output logic [3:0][REG_W-1:0] regs_o,
  output logic                  cmp2_flag_o
);
  setup_t           cfg_q;
  logic [CNT_W-1:0] cnt_q, cmp1_q, cmp2_q;
  logic             wr_setup, wr_cnt, hit1, hit2, clr1, clr2, step;

  assign wr_setup = wr_en && (wr_sel == SEL_SETUP);
  assign wr_cnt   = wr_en && (wr_sel == SEL_COUNT);
  assign hit1     = cfg_q.run && cfg_q.c1en && (cnt_q == cmp1_q);
  assign hit2     = cfg_q.run && cfg_q.c2en && (cnt_q == cmp2_q);
  assign clr1     = wr_setup && wr_data[SET_F1];
  assign clr2     = wr_setup && wr_data[SET_F2];

  mft_prescaler #(.EXP_W(PRE_BITS)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (cfg_q.run),
    .src    (cfg_q.fast || tick_i),
    .exp_i  (cfg_q.pre),
    .step_o (step)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      cmp1_q <= '0;
      cmp2_q <= '0;
    end else begin
      if (wr_setup) begin
        cfg_q.run <= wr_data[SET_RUN];
        if (!cfg_q.lock) begin
          cfg_q.lock <= 1'b1;
          cfg_q.c2en <= wr_data[SET_C2EN];
          cfg_q.c1en <= wr_data[SET_C1EN];
          cfg_q.fast <= wr_data[SET_FAST];
          cfg_q.pre  <= wr_data[PRE_BITS-1:0];
        end
      end
      cfg_q.f1 <= clr1 ? 1'b0 : (cfg_q.f1 || hit1);
      cfg_q.f2 <= clr2 ? 1'b0 : (cfg_q.f2 || hit2);
      if (wr_en && (wr_sel == SEL_CMP1)) cmp1_q <= wr_data[CNT_W-1:0];
      if (wr_en && (wr_sel == SEL_CMP2)) cmp2_q <= wr_data[CNT_W-1:0];
      if (wr_cnt) begin
        cnt_q <= wr_data[CNT_W-1:0];
      end else if (step && (cnt_q != {CNT_W{1'b1}})) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign regs_o[0]   = REG_W'(cmp1_q);
  assign regs_o[1]   = REG_W'(cmp2_q);
  assign regs_o[2]   = REG_W'(cnt_q);
  assign regs_o[3]   = setup_word(cfg_q);
  assign cmp2_flag_o = cfg_q.f2;

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.run && !wr_cnt) |=> $stable(cnt_q));
  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == {CNT_W{1'b1}}) && !wr_cnt) |=> (cnt_q == {CNT_W{1'b1}}));
  // R3
  frozen_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.lock |=> $stable({cfg_q.c2en, cfg_q.c1en, cfg_q.fast, cfg_q.pre}));
  // R8
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.f2 && !clr2) |=> cfg_q.f2);
endmodule

// File: rtl/mft_bank.sv
module mft_bank
  import mft_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic                irq_cfg_wr,
  input  logic [2*NUM_CH-1:0] irq_cfg_wdata,
  output logic                rst_req_o,
  output logic                nmi_req_o
);
  logic [CH_W-1:0]         ch_idx;
  logic [3:0][REG_W-1:0]   ch_regs [NUM_CH];
  logic [NUM_CH-1:0]       flag2;
  logic [2*NUM_CH-1:0]     irq_cfg_q;

  assign ch_idx = bus_addr[ADDR_W-1:2];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    mft_channel #(.CNT_W(CNT_W)) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_i),
      .wr_en       (bus_wr && (ch_idx == CH_W'(g))),
      .wr_sel      (reg_sel_e'(bus_addr[1:0])),
      .wr_data     (bus_wdata),
      .regs_o      (ch_regs[g]),
      .cmp2_flag_o (flag2[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_idx == CH_W'(i)) bus_rdata = ch_regs[i][bus_addr[1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          irq_cfg_q <= '0;
    else if (irq_cfg_wr) irq_cfg_q <= irq_cfg_wdata;
  end

  assign rst_req_o = |(flag2 & irq_cfg_q[2*NUM_CH-1:NUM_CH]);
  assign nmi_req_o = |(flag2 & irq_cfg_q[NUM_CH-1:0]);

  // R9
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_o && !irq_cfg_wr && !bus_wr) |=> rst_req_o);
  // R9
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req_o && !irq_cfg_wr && !bus_wr) |=> nmi_req_o);
endmodule

// File: tb/mft_bank_bench.sv
module mft_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_cfg_wr = 1'b0;
  logic [11:0] irq_cfg_wdata = '0;
  logic        rst_req_o, nmi_req_o;

  logic        rd_req = 1'b0;
  logic        e_rst = 1'b0, e_nmi = 1'b0;
  logic [15:0] q_data[$];
  logic        q_rst[$];
  logic        q_nmi[$];
  string       q_tag[$];
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  mft_bank u_mft_bank (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_cfg_wr(irq_cfg_wr), .irq_cfg_wdata(irq_cfg_wdata),
    .rst_req_o(rst_req_o), .nmi_req_o(nmi_req_o)
  );

  // monitor: pops the scoreboard away from the active edge
  always @(negedge clk) begin
    if (rd_req && q_data.size() > 0) begin
      logic [15:0] xd;
      logic        xr, xn;
      string       t;
      xd = q_data.pop_front();
      xr = q_rst.pop_front();
      xn = q_nmi.pop_front();
      t  = q_tag.pop_front();
      n_chk++;
      if (bus_rdata !== xd || rst_req_o !== xr || nmi_req_o !== xn) begin
        n_fail++;
        $display("FAIL %s: rdata=%h rst=%b nmi=%b expected rdata=%h rst=%b nmi=%b",
                 t, bus_rdata, rst_req_o, nmi_req_o, xd, xr, xn);
      end
    end
  end

  task automatic wr(input int ch, input int sel, input logic [15:0] d);
    bus_addr = {3'(ch), 2'(sel)}; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1; bus_wr = 1'b0;
  endtask

  task automatic cfg(input logic [11:0] d);
    irq_cfg_wdata = d; irq_cfg_wr = 1'b1;
    @(posedge clk); #1; irq_cfg_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input int sel, input logic [15:0] x, input string tag);
    bus_addr = {3'(ch), 2'(sel)};
    q_data.push_back(x); q_rst.push_back(e_rst); q_nmi.push_back(e_nmi); q_tag.push_back(tag);
    rd_req = 1'b1;
    @(posedge clk); #1; rd_req = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) begin
      tick_i = 1'b1; @(posedge clk); #1; tick_i = 1'b0;
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state and free-channel scan
    rd(0, 3, 16'h0000, "R1 ch0 setup");
    rd(0, 2, 16'h0000, "R1 ch0 count");
    rd(5, 1, 16'h0000, "R1 ch5 cmp2");
    rd(4, 3, 16'h0000, "R1 ch4 setup free");
    // R2 first write, fast source exp 0; R6 one step per cycle
    wr(0, 3, 16'h8010);
    idle(4);
    wr(0, 3, 16'h0000);
    rd(0, 2, 16'd5, "R6 fast count");
    rd(0, 3, 16'h1010, "R2 locked setup");
    idle(5);
    rd(0, 2, 16'd5, "R5 held while stopped");
    // R3 locked fields ignore writes
    wr(0, 3, 16'h030F);
    rd(0, 3, 16'h1010, "R3 frozen fields");
    // R4 direct load
    wr(0, 2, 16'h1234);
    rd(0, 2, 16'h1234, "R4 load");
    // R7 saturation
    wr(0, 2, 16'hFFFD);
    wr(0, 3, 16'h8000);
    idle(4);
    wr(0, 3, 16'h0000);
    rd(0, 2, 16'hFFFF, "R7 saturate");
    // R8 / R9 compare flags and reset request on ch2
    wr(2, 0, 16'd4);
    wr(2, 1, 16'd10);
    cfg(12'h100);
    wr(2, 3, 16'h8310);
    idle(19);
    wr(2, 3, 16'h0000);
    e_rst = 1'b1;
    rd(2, 2, 16'd20, "R8 ch2 count");
    rd(2, 3, 16'h7310, "R8 flags set R9 rst");
    rd(2, 0, 16'd4, "R10 cmp1 select");
    rd(2, 1, 16'd10, "R10 cmp2 select");
    idle(10);
    rd(2, 3, 16'h7310, "R9 request held");
    cfg(12'h200); e_rst = 1'b0;
    rd(2, 3, 16'h7310, "R9 other channel bit");
    cfg(12'h004); e_nmi = 1'b1;
    rd(2, 3, 16'h7310, "R9 nmi bit");
    cfg(12'h104); e_rst = 1'b1;
    rd(2, 3, 16'h7310, "R9 both");
    // R3 write-1-to-clear
    wr(2, 3, 16'h4000); e_rst = 1'b0; e_nmi = 1'b0;
    rd(2, 3, 16'h3310, "R3 clear cmp2 flag");
    wr(2, 3, 16'h2000);
    rd(2, 3, 16'h1310, "R3 clear cmp1 flag");
    // R6 tick source, exp 2; R5 prescaler phase held
    wr(3, 3, 16'h8002);
    ticks(14);
    wr(3, 3, 16'h0000);
    rd(3, 2, 16'd3, "R6 tick prescale");
    ticks(5);
    rd(3, 2, 16'd3, "R5 ticks ignored stopped");
    wr(3, 3, 16'h8000);
    ticks(1);
    wr(3, 3, 16'h0000);
    rd(3, 2, 16'd3, "R5 phase partial");
    wr(3, 3, 16'h8000);
    ticks(1);
    wr(3, 3, 16'h0000);
    rd(3, 2, 16'd4, "R5 phase resumed");
    // R10 unused channel indices
    wr(6, 3, 16'h8310);
    rd(6, 3, 16'h0000, "R10 ch6 empty");
    rd(7, 0, 16'h0000, "R10 ch7 empty");
    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule